// File: doc/BRIEF.md
# Segment Descriptor Access Checker

This block sits between an address generator and the memory path. It takes a 36-bit segmented virtual address and a requested access type (read, write or execute). It finds the segment descriptor that the address names and checks the request against that descriptor. It then returns either a physical word address or a fault code.

The address carries three fields. A 3-bit level picks one of eight table-base registers. An index is added to that base to find the head descriptor. A 30-bit offset gives the position within the segment.

Descriptors live in a small internal store that software fills through a write port. Each descriptor holds:
- a valid flag;
- a size class;
- lower and upper offset limits;
- a lock made of a ring and a domain;
- a special and a general 3-bit permission set;
- a physical base.

A segment larger than one descriptor uses a run of consecutive descriptors. The upper offset bits step through that run, and each descriptor in the run supplies its own physical base.

The activity key is a ring and a domain. It is held in an internal register that changes only on an explicit load strobe, which marks a privilege transition. Requests enter through a valid/ready handshake. The result leaves through a registered valid/ready output stage, one cycle after acceptance.

Top module: `sdac_top`

## Requirements
- R1: The address is laid out as `req_va[35:33]` = level, `req_va[32:30]` = index and `req_va[29:0]` = offset. The head descriptor number is the table base for that level plus the index. If that number is at or above the store depth, or the descriptor there is invalid, the fault is 3 (invalid descriptor). Fault codes are 0 none, 1 limit, 2 access denied and 3 invalid descriptor.
- R2: An offset below the head descriptor's lower limit, or above its upper limit, gives fault 1.
- R3: Size class codes are 0 small, 1 large, 2 very large and 3 reserved. The extension field is `offset[29:18]`. It must be 0 for a small class, below 64 for a large class and below 4096 for a very large class; otherwise the fault is 1. Class 3 gives fault 3.
- R4: The member descriptor number is the head number plus the extension. The physical address is the member's base plus `offset[17:0]`. A member that is out of range or invalid gives fault 3.
- R5: Special permissions apply when the key ring and key domain both equal the lock, or when the key ring is numerically below the lock ring. In every other case the general permissions apply.
- R6: Permission bit 0 grants read, bit 1 grants write and bit 2 grants execute. Access codes are 0 read, 1 write and 2 execute. A request whose selected bit is clear gives fault 2, and access code 3 always gives fault 2.
- R7: When several faults apply, they take priority in this order: head invalid (3), then limit (1), then member invalid (3), then access denied (2).
- R8: The key register loads `key_ring` and `key_dom` only in a cycle with `key_ld` high; those pins have no effect at other times. Reset sets the key to ring all-ones, domain 0.
- R9: A request is accepted when `req_valid` and `req_ready` are both high. Its result appears on `rsp_valid` in the next cycle and stays unchanged while `rsp_ready` is low. `req_ready` is high when the output stage is empty or is being drained.
- R10: A faulted response carries `rsp_addr` = 0. After reset, `rsp_valid` is low and every descriptor is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Write strobe for a table-base register |
| tbl_lvl | input | 3 | Level whose table base is written |
| tbl_ptr | input | $clog2(DEPTH) | New table base (descriptor number) |
| dsc_we | input | 1 | Write strobe for a descriptor |
| dsc_idx | input | $clog2(DEPTH) | Descriptor number to write |
| dsc_valid | input | 1 | Valid flag |
| dsc_size | input | 2 | Size class |
| dsc_lower | input | 30 | Lower offset limit |
| dsc_upper | input | 30 | Upper offset limit |
| dsc_ring | input | RING_W | Lock ring |
| dsc_dom | input | DOM_W | Lock domain |
| dsc_sperm | input | 3 | Special permission set |
| dsc_gperm | input | 3 | General permission set |
| dsc_base | input | PA_W | Physical base of this descriptor's span |
| key_ld | input | 1 | Transition strobe that loads the key |
| key_ring | input | RING_W | New key ring |
| key_dom | input | DOM_W | New key domain |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_va | input | 36 | Virtual address |
| req_acc | input | 2 | Access type |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result consumed |
| rsp_fault | output | 2 | Fault code |
| rsp_addr | output | PA_W | Physical address, or 0 on a fault |

## Verification
The hardest case to reach is a member-descriptor fault in a multi-descriptor segment. The offset must pass both the head limits and the size-class bound, while its extension lands on an invalid descriptor or steps past the end of the store. The bench builds this deliberately. It loads a large segment whose upper limit spans three descriptors and leaves the third invalid. It also loads a very large segment whose head sits near the top of the store. It then aims offsets at each of these members.

Key ring and domain combinations are reached through the load strobe. In addition, the key pins are moved without the strobe and the result on a descriptor is observed. This shows that the key did not change.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int VA_W   = 36;
  localparam int LVL_W  = 3;
  localparam int IDX_W  = 3;
  localparam int OFF_W  = 30;
  localparam int SEG_W  = 18;
  localparam int EXT_W  = OFF_W - SEG_W;
  localparam int NLVL   = 1 << LVL_W;
  localparam int LARGE_SPAN  = 64;
  localparam int VLARGE_SPAN = 4096;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_LIMIT = 2'd1,
    FLT_DENY  = 2'd2,
    FLT_INVAL = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    SZ_SMALL  = 2'd0,
    SZ_LARGE  = 2'd1,
    SZ_VLARGE = 2'd2,
    SZ_RSV    = 2'd3
  } size_e;
endpackage

// File: rtl/sdac_store.sv
module sdac_store #(
  parameter int DEPTH  = 16,
  parameter int RING_W = 2,
  parameter int DOM_W  = 6,
  parameter int PA_W   = 36
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] w_idx,
  input  logic                     w_valid,
  input  logic [1:0]               w_size,
  input  logic [29:0]              w_lower,
  input  logic [29:0]              w_upper,
  input  logic [RING_W-1:0]        w_ring,
  input  logic [DOM_W-1:0]         w_dom,
  input  logic [2:0]               w_sp,
  input  logic [2:0]               w_gp,
  input  logic [PA_W-1:0]          w_base,
  input  logic [$clog2(DEPTH)-1:0] h_idx,
  output logic                     h_valid,
  output logic [1:0]               h_size,
  output logic [29:0]              h_lower,
  output logic [29:0]              h_upper,
  output logic [RING_W-1:0]        h_ring,
  output logic [DOM_W-1:0]         h_dom,
  output logic [2:0]               h_sp,
  output logic [2:0]               h_gp,
  input  logic [$clog2(DEPTH)-1:0] m_idx,
  output logic                     m_valid,
  output logic [PA_W-1:0]          m_base
);
  logic [DEPTH-1:0]  vld_q;
  logic [1:0]        size_q  [DEPTH];
  logic [29:0]       lower_q [DEPTH];
  logic [29:0]       upper_q [DEPTH];
  logic [RING_W-1:0] ring_q  [DEPTH];
  logic [DOM_W-1:0]  dom_q   [DEPTH];
  logic [2:0]        sp_q    [DEPTH];
  logic [2:0]        gp_q    [DEPTH];
  logic [PA_W-1:0]   base_q  [DEPTH];

  // only the valid flags need a defined reset value
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  vld_q        <= '0;
    else if (we) vld_q[w_idx] <= w_valid;
  end

  always_ff @(posedge clk) begin
    if (we) begin
      size_q[w_idx]  <= w_size;
      lower_q[w_idx] <= w_lower;
      upper_q[w_idx] <= w_upper;
      ring_q[w_idx]  <= w_ring;
      dom_q[w_idx]   <= w_dom;
      sp_q[w_idx]    <= w_sp;
      gp_q[w_idx]    <= w_gp;
      base_q[w_idx]  <= w_base;
    end
  end

  always_comb begin
    h_valid = vld_q[h_idx];
    h_size  = size_q[h_idx];
    h_lower = lower_q[h_idx];
    h_upper = upper_q[h_idx];
    h_ring  = ring_q[h_idx];
    h_dom   = dom_q[h_idx];
    h_sp    = sp_q[h_idx];
    h_gp    = gp_q[h_idx];
    m_valid = vld_q[m_idx];
    m_base  = base_q[m_idx];
  end
endmodule

// File: rtl/sdac_perm.sv
module sdac_perm #(
  parameter int RING_W = 2,
  parameter int DOM_W  = 6
) (
  input  logic [RING_W-1:0] key_ring,
  input  logic [DOM_W-1:0]  key_dom,
  input  logic [RING_W-1:0] lock_ring,
  input  logic [DOM_W-1:0]  lock_dom,
  input  logic [2:0]        sp,
  input  logic [2:0]        gp,
  input  logic [1:0]        acc,
  output logic              allow
);
  import sdac_pkg::*;
  logic       special;
  logic [2:0] perm;

  always_comb begin
    special = ((key_ring == lock_ring) && (key_dom == lock_dom)) ||
              (key_ring < lock_ring);
    perm    = special ? sp : gp;
    unique case (acc_e'(acc))
      ACC_RD:  allow = perm[0];
      ACC_WR:  allow = perm[1];
      ACC_EX:  allow = perm[2];
      default: allow = 1'b0;
    endcase
  end
endmodule

// File: rtl/sdac_limit.sv
module sdac_limit (
  input  logic [sdac_pkg::OFF_W-1:0] off,
  input  logic [29:0]                lower,
  input  logic [29:0]                upper,
  input  logic [1:0]                 size,
  output logic                       limit_flt
);
  import sdac_pkg::*;
  logic [EXT_W-1:0] ext;
  logic             span_ok;

  always_comb begin
    ext = off[OFF_W-1:SEG_W];
    unique case (size_e'(size))
      SZ_SMALL:  span_ok = (ext == '0);
      SZ_LARGE:  span_ok = ({1'b0, ext} < (EXT_W+1)'(LARGE_SPAN));
      SZ_VLARGE: span_ok = ({1'b0, ext} < (EXT_W+1)'(VLARGE_SPAN));
      default:   span_ok = 1'b1;
    endcase
    limit_flt = (off < lower) || (off > upper) || !span_ok;
  end
endmodule

// File: rtl/sdac_top.sv
module sdac_top #(
  parameter int DEPTH  = 16,
  parameter int RING_W = 2,
  parameter int DOM_W  = 6,
  parameter int PA_W   = 36
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tbl_we,
  input  logic [2:0]               tbl_lvl,
  input  logic [$clog2(DEPTH)-1:0] tbl_ptr,
  input  logic                     dsc_we,
  input  logic [$clog2(DEPTH)-1:0] dsc_idx,
  input  logic                     dsc_valid,
  input  logic [1:0]               dsc_size,
  input  logic [29:0]              dsc_lower,
  input  logic [29:0]              dsc_upper,
  input  logic [RING_W-1:0]        dsc_ring,
  input  logic [DOM_W-1:0]         dsc_dom,
  input  logic [2:0]               dsc_sperm,
  input  logic [2:0]               dsc_gperm,
  input  logic [PA_W-1:0]          dsc_base,
  input  logic                     key_ld,
  input  logic [RING_W-1:0]        key_ring,
  input  logic [DOM_W-1:0]         key_dom,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [35:0]              req_va,
  input  logic [1:0]               req_acc,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [1:0]               rsp_fault,
  output logic [PA_W-1:0]          rsp_addr
);
  import sdac_pkg::*;

  localparam int AW    = $clog2(DEPTH);
  localparam int SUM_W = ((AW > EXT_W) ? AW : EXT_W) + 2;

  // table-base registers, one per level
  logic [AW-1:0] tbl_q [NLVL];
  genvar gl;
  generate
    for (gl = 0; gl < NLVL; gl++) begin : g_lvl
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  tbl_q[gl] <= '0;
        else if (tbl_we && (tbl_lvl == LVL_W'(gl)))  tbl_q[gl] <= tbl_ptr;
      end
    end
  endgenerate

  // activity key, changed only on a transition strobe
  logic [RING_W-1:0] key_ring_q;
  logic [DOM_W-1:0]  key_dom_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_ring_q <= '1;
      key_dom_q  <= '0;
    end else if (key_ld) begin
      key_ring_q <= key_ring;
      key_dom_q  <= key_dom;
    end
  end

  // address fields and descriptor numbers
  logic [LVL_W-1:0] va_lvl;
  logic [IDX_W-1:0] va_idx;
  logic [OFF_W-1:0] va_off;
  logic [SUM_W-1:0] head_sum, mem_sum;
  logic             head_oor, mem_oor;

  always_comb begin
    va_lvl   = req_va[VA_W-1 -: LVL_W];
    va_idx   = req_va[OFF_W +: IDX_W];
    va_off   = req_va[OFF_W-1:0];
    head_sum = SUM_W'(tbl_q[va_lvl]) + SUM_W'(va_idx);
    mem_sum  = head_sum + SUM_W'(va_off[OFF_W-1:SEG_W]);
    head_oor = head_sum >= SUM_W'(DEPTH);
    mem_oor  = mem_sum  >= SUM_W'(DEPTH);
  end

  logic              h_valid, m_valid;
  logic [1:0]        h_size;
  logic [29:0]       h_lower, h_upper;
  logic [RING_W-1:0] h_ring;
  logic [DOM_W-1:0]  h_dom;
  logic [2:0]        h_sp, h_gp;
  logic [PA_W-1:0]   m_base;

  sdac_store #(.DEPTH(DEPTH), .RING_W(RING_W), .DOM_W(DOM_W), .PA_W(PA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .we(dsc_we), .w_idx(dsc_idx), .w_valid(dsc_valid), .w_size(dsc_size),
    .w_lower(dsc_lower), .w_upper(dsc_upper), .w_ring(dsc_ring), .w_dom(dsc_dom),
    .w_sp(dsc_sperm), .w_gp(dsc_gperm), .w_base(dsc_base),
    .h_idx(head_sum[AW-1:0]), .h_valid(h_valid), .h_size(h_size),
    .h_lower(h_lower), .h_upper(h_upper), .h_ring(h_ring), .h_dom(h_dom),
    .h_sp(h_sp), .h_gp(h_gp),
    .m_idx(mem_sum[AW-1:0]), .m_valid(m_valid), .m_base(m_base)
  );

  logic allow;
  sdac_perm #(.RING_W(RING_W), .DOM_W(DOM_W)) u_perm (
    .key_ring(key_ring_q), .key_dom(key_dom_q),
    .lock_ring(h_ring), .lock_dom(h_dom),
    .sp(h_sp), .gp(h_gp), .acc(req_acc), .allow(allow)
  );

  logic limit_flt;
  sdac_limit u_limit (
    .off(va_off), .lower(h_lower), .upper(h_upper), .size(h_size),
    .limit_flt(limit_flt)
  );

  // fault resolution in priority order
  fault_e          flt_c;
  logic [PA_W-1:0] addr_c;
  always_comb begin
    if (head_oor || !h_valid || (size_e'(h_size) == SZ_RSV)) flt_c = FLT_INVAL;
    else if (limit_flt)                                      flt_c = FLT_LIMIT;
    else if (mem_oor || !m_valid)                            flt_c = FLT_INVAL;
    else if (!allow)                                         flt_c = FLT_DENY;
    else                                                     flt_c = FLT_NONE;
    addr_c = (flt_c == FLT_NONE) ? (m_base + PA_W'(va_off[SEG_W-1:0])) : '0;
  end

  // output stage: next-state, then registers
  logic            accept;
  logic            vld_d, vld_q;
  logic [1:0]      flt_d, flt_q;
  logic [PA_W-1:0] addr_d, addr_q;

  always_comb begin
    req_ready = !vld_q || rsp_ready;
    accept    = req_valid && req_ready;
    vld_d     = accept || (vld_q && !rsp_ready);
    flt_d     = accept ? flt_c  : flt_q;
    addr_d    = accept ? addr_c : addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_q  <= '0;
      addr_q <= '0;
    end else if (accept) begin
      flt_q  <= flt_d;
      addr_q <= addr_d;
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_fault = flt_q;
  assign rsp_addr  = addr_q;
endmodule

// File: rtl/sdac_chk.sv
module sdac_chk #(
  parameter int RING_W = 2,
  parameter int DOM_W  = 6,
  parameter int PA_W   = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [1:0]        rsp_fault,
  input logic [PA_W-1:0]   rsp_addr,
  input logic              key_ld,
  input logic [RING_W-1:0] key_ring,
  input logic [DOM_W-1:0]  key_dom,
  input logic [RING_W-1:0] key_ring_q,
  input logic [DOM_W-1:0]  key_dom_q
);
  assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_fault) && $stable(rsp_addr));

  assert_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready && !req_valid |=> !rsp_valid);

  assert_fault_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_fault != 2'd0) |-> rsp_addr == '0);

  assert_key_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !key_ld |=> $stable(key_ring_q) && $stable(key_dom_q));

  assert_key_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    key_ld |=> (key_ring_q == $past(key_ring)) && (key_dom_q == $past(key_dom)));
endmodule

bind sdac_top sdac_chk #(.RING_W(RING_W), .DOM_W(DOM_W), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
  .rsp_addr(rsp_addr), .key_ld(key_ld), .key_ring(key_ring), .key_dom(key_dom),
  .key_ring_q(key_ring_q), .key_dom_q(key_dom_q)
);

// File: tb/sim_sdac_top.sv
module sim_sdac_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_we = 0;
  logic [2:0]  tbl_lvl = 0;
  logic [3:0]  tbl_ptr = 0;
  logic        dsc_we = 0;
  logic [3:0]  dsc_idx = 0;
  logic        dsc_valid = 0;
  logic [1:0]  dsc_size = 0;
  logic [29:0] dsc_lower = 0, dsc_upper = 0;
  logic [1:0]  dsc_ring = 0;
  logic [5:0]  dsc_dom = 0;
  logic [2:0]  dsc_sperm = 0, dsc_gperm = 0;
  logic [35:0] dsc_base = 0;
  logic        key_ld = 0;
  logic [1:0]  key_ring = 0;
  logic [5:0]  key_dom = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [35:0] req_va = 0;
  logic [1:0]  req_acc = 0;
  logic        rsp_valid;
  logic        rsp_ready = 1;
  logic [1:0]  rsp_fault;
  logic [35:0] rsp_addr;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  sdac_top u0 (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_tbl(logic [2:0] lvl, logic [3:0] ptr);
    @(negedge clk);
    tbl_we = 1; tbl_lvl = lvl; tbl_ptr = ptr;
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic wr_dsc(logic [3:0] idx, logic v, logic [1:0] sz, logic [29:0] lo,
                        logic [29:0] up, logic [1:0] rg, logic [5:0] dm,
                        logic [2:0] sp, logic [2:0] gp, logic [35:0] base);
    @(negedge clk);
    dsc_we = 1; dsc_idx = idx; dsc_valid = v; dsc_size = sz; dsc_lower = lo;
    dsc_upper = up; dsc_ring = rg; dsc_dom = dm; dsc_sperm = sp; dsc_gperm = gp;
    dsc_base = base;
    @(negedge clk);
    dsc_we = 0;
  endtask

  task automatic ld_key(logic [1:0] rg, logic [5:0] dm);
    @(negedge clk);
    key_ld = 1; key_ring = rg; key_dom = dm;
    @(negedge clk);
    key_ld = 0;
  endtask

  // one request with the output stage free; result sampled at the next negedge
  task automatic do_req(logic [35:0] va, logic [1:0] acc,
                        output logic v, output logic [1:0] f, output logic [35:0] a);
    @(negedge clk);
    req_va = va; req_acc = acc; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    v = rsp_valid; f = rsp_fault; a = rsp_addr;
  endtask

  // {req tag, level, index, offset, access, fault, address}
  localparam logic [79:0] VEC [16] = '{
    {4'd1,  3'd0, 3'd0, 30'h20,     2'd1, 2'd0, 36'h1000020}, // R1 special write
    {4'd2,  3'd0, 3'd0, 30'h0F,     2'd0, 2'd1, 36'h0},       // R2 below lower
    {4'd3,  3'd0, 3'd0, 30'h40000,  2'd0, 2'd1, 36'h0},       // R3 small span exceeded
    {4'd5,  3'd0, 3'd1, 30'h80,     2'd0, 2'd2, 36'h0},       // R5 general, none granted
    {4'd7,  3'd0, 3'd1, 30'h100,    2'd0, 2'd1, 36'h0},       // R7 limit beats denial
    {4'd1,  3'd0, 3'd2, 30'h5,      2'd0, 2'd3, 36'h0},       // R1 invalid head
    {4'd4,  3'd1, 3'd0, 30'h40005,  2'd2, 2'd0, 36'h4000005}, // R4 second member
    {4'd6,  3'd1, 3'd0, 30'h40005,  2'd1, 2'd2, 36'h0},       // R6 write not granted
    {4'd4,  3'd1, 3'd0, 30'h80000,  2'd0, 2'd3, 36'h0},       // R4 invalid member
    {4'd2,  3'd1, 3'd0, 30'hC0000,  2'd0, 2'd1, 36'h0},       // R2 above upper
    {4'd3,  3'd2, 3'd0, 30'h0,      2'd0, 2'd3, 36'h0},       // R3 reserved class
    {4'd5,  3'd2, 3'd1, 30'h180010, 2'd1, 2'd0, 36'h5000010}, // R5 lower ring wins
    {4'd4,  3'd2, 3'd1, 30'h400000, 2'd0, 2'd3, 36'h0},       // R4 member past store
    {4'd1,  3'd7, 3'd3, 30'h0,      2'd0, 2'd3, 36'h0},       // R1 head past store
    {4'd6,  3'd0, 3'd0, 30'h20,     2'd3, 2'd2, 36'h0},       // R6 reserved access
    {4'd6,  3'd0, 3'd0, 30'h20,     2'd2, 2'd0, 36'h1000020}  // R6 execute granted
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    logic        v;
    logic [1:0]  f;
    logic [35:0] a;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    chk("R9 req_ready after reset", 64'(req_ready), 64'd1);
    do_req({3'd0, 3'd0, 30'h20}, 2'd0, v, f, a);
    chk("R10 empty store fault", 64'(f), 64'd3);
    chk("R9 rsp_valid after accept", 64'(v), 64'd1);
    @(negedge clk);
    chk("R9 rsp_valid drained", 64'(rsp_valid), 64'd0);

    wr_tbl(3'd0, 4'd0);
    wr_tbl(3'd1, 4'd4);
    wr_tbl(3'd2, 4'd8);
    wr_tbl(3'd7, 4'd14);
    wr_dsc(4'd0,  1, 2'd0, 30'h10, 30'hFFFFF,     2'd2, 6'd5, 3'b111, 3'b001, 36'h1000000);
    wr_dsc(4'd1,  1, 2'd0, 30'h0,  30'hFF,        2'd1, 6'd3, 3'b011, 3'b000, 36'h2000000);
    wr_dsc(4'd2,  0, 2'd0, 30'h0,  30'hFF,        2'd2, 6'd5, 3'b111, 3'b111, 36'h0);
    wr_dsc(4'd4,  1, 2'd1, 30'h0,  30'hBFFFF,     2'd2, 6'd5, 3'b101, 3'b000, 36'h3000000);
    wr_dsc(4'd5,  1, 2'd1, 30'h0,  30'h0,         2'd0, 6'd0, 3'b000, 3'b000, 36'h4000000);
    wr_dsc(4'd6,  0, 2'd1, 30'h0,  30'h0,         2'd0, 6'd0, 3'b000, 3'b000, 36'h0);
    wr_dsc(4'd8,  1, 2'd3, 30'h0,  30'h3FFFFFFF,  2'd2, 6'd5, 3'b111, 3'b111, 36'h0);
    wr_dsc(4'd9,  1, 2'd2, 30'h0,  30'h3FFFFFFF,  2'd3, 6'd9, 3'b111, 3'b000, 36'h6000000);
    wr_dsc(4'd15, 1, 2'd2, 30'h0,  30'h0,         2'd0, 6'd0, 3'b000, 3'b000, 36'h5000000);
    ld_key(2'd2, 6'd5);

    for (int i = 0; i < 16; i++) begin
      logic [79:0] e;
      e = VEC[i];
      do_req(e[75:40], e[39:38], v, f, a);
      chk($sformatf("R%0d vector %0d valid", e[79:76], i), 64'(v), 64'd1);
      chk($sformatf("R%0d vector %0d fault", e[79:76], i), 64'(f), 64'(e[37:36]));
      chk($sformatf("R%0d vector %0d addr", e[79:76], i), 64'(a), 64'(e[35:0]));
    end

    // R8: key pins move without the strobe; descriptor 0 still grants write
    @(negedge clk);
    key_ring = 2'd3; key_dom = 6'd0;
    repeat (2) @(negedge clk);
    do_req({3'd0, 3'd0, 30'h20}, 2'd1, v, f, a);
    chk("R8 key pins ignored without strobe", 64'(f), 64'd0);
    ld_key(2'd3, 6'd0);
    do_req({3'd0, 3'd0, 30'h20}, 2'd1, v, f, a);
    chk("R5 general set denies write", 64'(f), 64'd2);
    do_req({3'd0, 3'd0, 30'h20}, 2'd0, v, f, a);
    chk("R5 general set grants read", 64'(f), 64'd0);
    ld_key(2'd1, 6'd7);
    do_req({3'd0, 3'd0, 30'h20}, 2'd1, v, f, a);
    chk("R5 lower key ring grants write", 64'(f), 64'd0);
    ld_key(2'd2, 6'd6);
    do_req({3'd0, 3'd0, 30'h20}, 2'd1, v, f, a);
    chk("R5 equal ring other domain", 64'(f), 64'd2);

    // R9 back-pressure: result held while rsp_ready is low
    ld_key(2'd2, 6'd5);
    @(negedge clk);
    rsp_ready = 0;
    req_va = {3'd1, 3'd0, 30'h40005}; req_acc = 2'd0; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    for (int c = 0; c < 3; c++) begin
      chk("R9 stalled valid", 64'(rsp_valid), 64'd1);
      chk("R9 stalled ready low", 64'(req_ready), 64'd0);
      chk("R9 stalled addr", 64'(rsp_addr), 64'h4000005);
      @(negedge clk);
    end
    rsp_ready = 1;
    @(negedge clk);
    chk("R9 released drains", 64'(rsp_valid), 64'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule